// File: doc/BRIEF.md
# Geometry-Mismatch Alias Memory

This block stands in for a memory chip whose real row, bank and column widths are fixed by a parameter, while boot firmware programs a trial geometry and probes addresses to find out how large the part really is. Every access offset is cut into column, bank and row fields using the trial widths. Each field is then reduced to the position of its highest set bit, looking only at bit positions that exist on the real chip. The three positions pick one cell in a small store. Many offsets therefore land on the same cell, and firmware that writes a pattern at one address and finds it again at another concludes what real silicon would.

The block answers accesses only while its window is open. The window opens once a trial geometry has been loaded and at least one of its widths differs from the real chip's widths. When the widths match, the block stays silent so that the access can be served by ordinary memory. If the configured size is not one the block knows, every acknowledged read returns zero and writes are dropped.

Top module: `gma_top`

## Requirements
- R1: The offset is split with the column field in bits [C-1:0], the bank field in the next B bits and the row field in the R bits above that, where C, B and R are the loaded trial widths.
- R2: Each cell index is the position of the highest set bit of its field, counting only positions below the real chip's width for that field; a field with no such bit set gives index 0.
- R3: The real widths follow the size parameter in MiB: 256 gives 12 row bits, 512 gives 13, 1024 gives 14; all three have 3 bank bits and 13 column bits.
- R4: After reset the window is closed; it stays closed until a geometry is loaded, and for a known size it is open exactly when a loaded width differs from the real one.
- R5: A new geometry takes effect in the cycle after the load strobe, and cell contents survive a geometry change.
- R6: An access presented while the window is open is acknowledged in the next cycle; a write stores its data in the selected cell and a read returns the selected cell's content with that acknowledge.
- R7: An access presented while the window is closed is not acknowledged and a write in that state leaves every cell unchanged.
- R8: For a size other than 256, 512 or 1024 the window opens on the first geometry load, acknowledged reads return zero and writes are discarded.
- R9: Two offsets whose three fields have the same highest set bits, within the real widths, reach the same cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Load strobe for the trial geometry |
| cfg_row_bits | input | 5 | Trial row field width |
| cfg_bank_bits | input | 2 | Trial bank field width |
| cfg_col_bits | input | 5 | Trial column field width |
| acc_valid | input | 1 | Access request, one cycle per access |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_offset | input | OFS_W | Byte offset into the memory |
| acc_wdata | input | DATA_W | Write data |
| acc_ack | output | 1 | Access taken by this block, one cycle after the request |
| acc_rdata | output | DATA_W | Read data, valid with acc_ack |
| win_en | output | 1 | Alias window open |

## Verification
The main sweep loads a geometry that is narrower in bank and column and wider in row than the real chip, writes every combination of a single set bit (or none) per field, and reads each cell back through offsets that also have every lower bit of each field set; agreement shows the field split and the highest-bit reduction, while row bits above the real width fold onto index 0. A second, different mismatching geometry reaches the same cells through other offsets and tells retention apart from rewriting. Writes made with matching widths, later read back through an open window, separate a silent block from one that stores quietly, and a twin instance with an unknown size shows zero reads alongside acknowledges.

// File: rtl/gma_pkg.sv
package gma_pkg;

    localparam int ROW_SLOTS  = 16;
    localparam int BANK_SLOTS = 3;
    localparam int COL_SLOTS  = 13;
    localparam int CELL_COUNT = ROW_SLOTS * BANK_SLOTS * COL_SLOTS;
    localparam int CELL_AW    = $clog2(CELL_COUNT);

    typedef struct packed {
        logic [4:0] row_w;
        logic [1:0] bank_w;
        logic [4:0] col_w;
    } geom_t;

    typedef struct packed {
        logic [3:0] row;
        logic [1:0] bank;
        logic [3:0] col;
    } cell_idx_t;

    function automatic logic size_known(int mb);
        return (mb == 256) || (mb == 512) || (mb == 1024);
    endfunction

    function automatic geom_t true_geom(int mb);
        geom_t g;
        g = '0;
        if (size_known(mb)) begin
            g.bank_w = 2'd3;
            g.col_w  = 5'd13;
            g.row_w  = (mb == 256) ? 5'd12 : ((mb == 512) ? 5'd13 : 5'd14);
        end
        return g;
    endfunction

    function automatic logic [31:0] pick_field(logic [31:0] ofs, logic [5:0] lsb,
                                               logic [4:0] width);
        logic [63:0] wide;
        logic [63:0] mask;
        wide = {32'd0, ofs} >> lsb;
        mask = (64'd1 << width) - 64'd1;
        return 32'(wide & mask);
    endfunction

    function automatic logic [4:0] top_bit(logic [31:0] v, int limit);
        logic [4:0] r;
        r = '0;
        for (int i = 0; i < 32; i++) begin
            if (i < limit && v[i]) r = 5'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/gma_geom.sv
module gma_geom
    import gma_pkg::*;
#(
    parameter int REAL_MB = 256
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  cfg_valid,
    input  geom_t cfg_in,
    output geom_t geom_q,
    output logic  win_en
);
    localparam geom_t REAL    = true_geom(REAL_MB);
    localparam logic  CHIP_OK = size_known(REAL_MB);

    logic loaded_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            geom_q   <= '0;
            loaded_q <= 1'b0;
        end else if (cfg_valid) begin
            geom_q   <= cfg_in;
            loaded_q <= 1'b1;
        end
    end

    assign win_en = loaded_q && (!CHIP_OK || (geom_q != REAL));

    p_en_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !cfg_valid |=> $stable(win_en))
        else $error("window changed without a geometry load");

endmodule

// File: rtl/gma_decode.sv
module gma_decode
    import gma_pkg::*;
#(
    parameter int REAL_MB = 256,
    parameter int OFS_W   = 32
) (
    input  geom_t              geom,
    input  logic [OFS_W-1:0]   offset,
    output cell_idx_t          idx,
    output logic [CELL_AW-1:0] addr
);
    localparam geom_t REAL = true_geom(REAL_MB);

    logic [31:0] ofs32;
    logic [5:0]  bank_lsb;
    logic [5:0]  row_lsb;
    logic [31:0] col_f;
    logic [31:0] bank_f;
    logic [31:0] row_f;
    logic [4:0]  row_t;
    logic [4:0]  bank_t;
    logic [4:0]  col_t;
    int          flat;

    always_comb begin
        ofs32    = 32'(offset);
        bank_lsb = 6'(geom.col_w);
        row_lsb  = 6'(geom.col_w) + 6'(geom.bank_w);
        col_f    = pick_field(ofs32, 6'd0, geom.col_w);
        bank_f   = pick_field(ofs32, bank_lsb, 5'(geom.bank_w));
        row_f    = pick_field(ofs32, row_lsb, geom.row_w);
        row_t    = top_bit(row_f, int'(REAL.row_w));
        bank_t   = top_bit(bank_f, int'(REAL.bank_w));
        col_t    = top_bit(col_f, int'(REAL.col_w));
        idx.row  = row_t[3:0];
        idx.bank = bank_t[1:0];
        idx.col  = col_t[3:0];
        flat     = (int'(idx.row) * BANK_SLOTS + int'(idx.bank)) * COL_SLOTS
                   + int'(idx.col);
        addr     = CELL_AW'(flat);
    end

endmodule

// File: rtl/gma_cells.sv
module gma_cells
    import gma_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [CELL_AW-1:0] addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata
);
    logic [DATA_W-1:0] store [CELL_COUNT];

    always_ff @(posedge clk) begin
        if (wr_en) store[addr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= store[addr];
        else            rdata <= '0;
    end

endmodule

// File: rtl/gma_top.sv
module gma_top
    import gma_pkg::*;
#(
    parameter int REAL_MB = 256,
    parameter int OFS_W   = 32,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_valid,
    input  logic [4:0]        cfg_row_bits,
    input  logic [1:0]        cfg_bank_bits,
    input  logic [4:0]        cfg_col_bits,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [OFS_W-1:0]  acc_offset,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              acc_ack,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              win_en
);
    localparam logic CHIP_OK = size_known(REAL_MB);

    geom_t              cfg_in;
    geom_t              geom_q;
    cell_idx_t          idx;
    logic [CELL_AW-1:0] cell_addr;
    logic               take;
    logic               do_wr;
    logic               do_rd;

    assign cfg_in = '{row_w: cfg_row_bits, bank_w: cfg_bank_bits, col_w: cfg_col_bits};

    gma_geom #(.REAL_MB(REAL_MB)) u_geom (
        .clk      (clk),
        .rst      (rst),
        .cfg_valid(cfg_valid),
        .cfg_in   (cfg_in),
        .geom_q   (geom_q),
        .win_en   (win_en)
    );

    gma_decode #(.REAL_MB(REAL_MB), .OFS_W(OFS_W)) u_decode (
        .geom  (geom_q),
        .offset(acc_offset),
        .idx   (idx),
        .addr  (cell_addr)
    );

    assign take  = acc_valid && win_en;
    assign do_wr = take && acc_write && CHIP_OK;
    assign do_rd = take && !acc_write && CHIP_OK;

    gma_cells #(.DATA_W(DATA_W)) u_cells (
        .clk  (clk),
        .rst  (rst),
        .wr_en(do_wr),
        .rd_en(do_rd),
        .addr (cell_addr),
        .wdata(acc_wdata),
        .rdata(acc_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) acc_ack <= 1'b0;
        else     acc_ack <= take;
    end

    p_ack_open_r6: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && win_en) |=> acc_ack)
        else $error("open-window access not acknowledged");

    p_ack_closed_r7: assert property (@(posedge clk) disable iff (rst)
        !(acc_valid && win_en) |=> !acc_ack)
        else $error("acknowledge without an open-window access");

    p_zero_unknown_r8: assert property (@(posedge clk) disable iff (rst)
        acc_ack |-> (CHIP_OK || acc_rdata == '0))
        else $error("unknown size returned nonzero data");

    p_idx_range_r2: assert property (@(posedge clk) disable iff (rst)
        acc_valid |-> (idx.row < 4'd14 && idx.bank < 2'd3 && idx.col < 4'd13))
        else $error("cell index outside the real geometry");

endmodule

// File: tb/gma_top_test.sv
module gma_top_test;

    localparam int RROW = 12, RBANK = 3, RCOL = 13;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_valid = 1'b0;
    logic [4:0]  cfg_row_bits = '0;
    logic [1:0]  cfg_bank_bits = '0;
    logic [4:0]  cfg_col_bits = '0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [31:0] acc_offset = '0;
    logic [31:0] acc_wdata = '0;
    logic        ack_a, ack_b, win_a, win_b;
    logic [31:0] rd_a, rd_b;

    int n_chk = 0;
    int n_bad = 0;
    logic finished = 1'b0;
    logic [31:0] model [624];

    always #2 clk = ~clk;

    gma_top #(.REAL_MB(256)) uut (
        .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_row_bits(cfg_row_bits),
        .cfg_bank_bits(cfg_bank_bits), .cfg_col_bits(cfg_col_bits),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_offset(acc_offset),
        .acc_wdata(acc_wdata), .acc_ack(ack_a), .acc_rdata(rd_a), .win_en(win_a)
    );

    gma_top #(.REAL_MB(768)) uut_unk (
        .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_row_bits(cfg_row_bits),
        .cfg_bank_bits(cfg_bank_bits), .cfg_col_bits(cfg_col_bits),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_offset(acc_offset),
        .acc_wdata(acc_wdata), .acc_ack(ack_b), .acc_rdata(rd_b), .win_en(win_b)
    );

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_geom(input int r, input int b, input int c);
        @(negedge clk);
        cfg_row_bits = 5'(r); cfg_bank_bits = 2'(b); cfg_col_bits = 5'(c);
        cfg_valid = 1'b1;
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    task automatic access(input logic wr, input logic [31:0] ofs, input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_offset = ofs; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    function automatic longint field_bits(int p, logic fill);
        if (p < 0) return 0;
        return fill ? ((64'sd1 <<< (p + 1)) - 1) : (64'sd1 <<< p);
    endfunction

    function automatic logic [31:0] make_ofs(int r, int b, int c, logic fill,
                                             int gr, int gb, int gc);
        longint v;
        v = field_bits(c, fill) | (field_bits(b, fill) <<< gc)
            | (field_bits(r, fill) <<< (gc + gb));
        return 32'(v);
    endfunction

    function automatic int hsb(longint v, int lim);
        int r;
        r = 0;
        for (int i = 0; i < lim; i++) if (v[i]) r = i;
        return r;
    endfunction

    function automatic int cell_key(logic [31:0] ofs, int gr, int gb, int gc);
        longint o, cf, bf, rf;
        o  = longint'(ofs);
        cf = o & ((64'sd1 <<< gc) - 1);
        bf = (o >>> gc) & ((64'sd1 <<< gb) - 1);
        rf = (o >>> (gc + gb)) & ((64'sd1 <<< gr) - 1);
        return (hsb(rf, RROW) * 3 + hsb(bf, RBANK)) * 13 + hsb(cf, RCOL);
    endfunction

    function automatic logic [31:0] pattern(logic [31:0] ofs, int salt);
        return (ofs * 32'h9E3779B1) ^ 32'(salt * 32'h01010101) ^ 32'hA5C3_0000;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] ofs, d;
        int k;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R4: closed after reset
        check(!ack_a && !win_a, "R4 reset closed", {ack_a, win_a}, 0);
        check(!win_b, "R8 unknown size closed before load", win_b, 0);

        access(1'b0, 32'h40, 32'h0);
        check(!ack_a, "R4 no ack before load", ack_a, 0);
        check(!ack_b, "R8 no ack before load", ack_b, 0);

        // matching geometry keeps the window closed
        load_geom(RROW, RBANK, RCOL);
        check(!win_a, "R4 matching widths closed", win_a, 0);
        check(win_b, "R8 unknown size open after load", win_b, 1);
        access(1'b1, 32'h123, 32'hFFFF_FFFF);
        check(!ack_a, "R7 closed write not acked", ack_a, 0);
        check(ack_b, "R8 write acked", ack_b, 1);
        access(1'b0, 32'h123, 32'h0);
        check(ack_b && rd_b == 32'h0, "R8 read zero", rd_b, 0);

        // geometry A: rows wider, banks and columns narrower than real (R5)
        load_geom(14, 2, 10);
        check(win_a, "R4 R5 mismatch opens window", win_a, 1);
        for (int r = -1; r < 14; r++)
            for (int b = -1; b < 2; b++)
                for (int c = -1; c < 10; c++) begin
                    ofs = make_ofs(r, b, c, 1'b0, 14, 2, 10);
                    d = pattern(ofs, 1);
                    access(1'b1, ofs, d);
                    check(ack_a, "R6 write acked", ack_a, 1);
                    model[cell_key(ofs, 14, 2, 10)] = d;
                end
        // read back through offsets with every lower bit filled: R1 R2 R3 R9
        for (int r = -1; r < 14; r++)
            for (int b = -1; b < 2; b++)
                for (int c = -1; c < 10; c++) begin
                    ofs = make_ofs(r, b, c, 1'b1, 14, 2, 10);
                    k = cell_key(ofs, 14, 2, 10);
                    access(1'b0, ofs, 32'h0);
                    check(ack_a && rd_a == model[k], "R1 R2 R3 R9 alias read", rd_a, model[k]);
                    check(ack_b && rd_b == 32'h0, "R8 read zero", rd_b, 0);
                end

        // back-to-back write then read of one cell (R6)
        ofs = make_ofs(7, 1, 4, 1'b0, 14, 2, 10);
        access(1'b1, ofs, 32'hC0FF_EE01);
        access(1'b0, ofs, 32'h0);
        check(ack_a && rd_a == 32'hC0FF_EE01, "R6 read after write", rd_a, 32'hC0FF_EE01);
        model[cell_key(ofs, 14, 2, 10)] = 32'hC0FF_EE01;

        // geometry B: cells must be retained (R5)
        load_geom(16, 3, 13);
        check(win_a, "R5 second mismatch open", win_a, 1);
        for (int r = 0; r < 12; r++)
            for (int b = 0; b < 2; b++)
                for (int c = 0; c < 10; c++) begin
                    ofs = make_ofs(r, b, c, 1'b0, 16, 3, 13);
                    k = cell_key(ofs, 16, 3, 13);
                    access(1'b0, ofs, 32'h0);
                    check(ack_a && rd_a == model[k], "R5 retained across geometry", rd_a, model[k]);
                end

        // closed-window write must not land (R7)
        ofs = make_ofs(5, 1, 5, 1'b0, RROW, RBANK, RCOL);
        k = cell_key(ofs, RROW, RBANK, RCOL);
        load_geom(RROW, RBANK, RCOL);
        access(1'b1, ofs, 32'hDEAD_BEEF);
        check(!ack_a, "R7 closed write silent", ack_a, 0);
        load_geom(16, 3, 13);
        access(1'b0, make_ofs(5, 1, 5, 1'b0, 16, 3, 13), 32'h0);
        check(ack_a && rd_a == model[k], "R7 closed write discarded", rd_a, model[k]);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule